// File: doc/BRIEF.md
# Periodic Low Battery Detector

This controller supervises a supply voltage by duty-cycling an external 5-bit measurement converter. While the function is enabled it counts ticks of a slow timebase and pulses a measurement enable for a short window once per period, by default 8 ticks out of every 32768 of a 32.768 kHz timebase. That is roughly 250 µs in each second. The converter returns a code with a done strobe. Each code stands for 1.7 V plus 50 mV per LSB, and the block keeps the latest code as the readable voltage register.

Each accepted code is compared with a programmable 5-bit threshold, which resets to 0x14. One low reading does not raise an alarm. Only an unbroken run of four readings strictly below the threshold sets a sticky status flag. A status read clears the flag. The active-low interrupt line follows the flag only when the interrupt enable is set. When the block is enabled during sleep it also requests the slow oscillator that drives its timebase.

Top module: `lbd_ctrl`

## Requirements
- R1: After reset the threshold reads 0x14, the voltage register reads 0, the status flag is 0, irq_n is 1, meas_en is 0 and slow_osc_en is 0.
- R2: A cycle with thr_wr high loads thr_wdata into the threshold, and the new value is visible on thr_q after the next clock edge.
- R3: While func_en is high, meas_en is high for ACTIVE_TICKS of every PERIOD_TICKS ticks. The first window starts on the clock edge after func_en rises.
- R4: The status flag sets on the clock edge that accepts the fourth consecutive code strictly below the threshold.
- R5: An accepted code equal to or above the threshold resets the run of low readings to zero.
- R6: The status flag stays set until a cycle with stat_rd high clears it. After the flag is set, it can set again only after a fresh run of four low readings.
- R7: irq_n is low exactly when, one cycle earlier, the status flag was set and irq_en was high. With irq_en low, irq_n stays high even while the flag is set.
- R8: Each accepted meas_done loads meas_code into vbat_q on that clock edge. vbat_q holds its value otherwise.
- R9: While func_en is low, meas_en is 0, the tick timer and the run of low readings are reset, and meas_done is ignored, so vbat_q and the flag do not change.
- R10: slow_osc_en is the registered AND of func_en and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timebase tick, one clock wide |
| sleep | input | 1 | Chip is in its sleep state |
| func_en | input | 1 | Enables periodic measurement and comparison |
| irq_en | input | 1 | Unmasks the low-battery interrupt |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | 5 | Threshold write data |
| meas_done | input | 1 | Converter result valid strobe |
| meas_code | input | 5 | Converter result, 1.7 V + 50 mV per LSB |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| meas_en | output | 1 | Powers up the measurement path |
| slow_osc_en | output | 1 | Requests the slow oscillator |
| vbat_q | output | 5 | Latest accepted voltage code |
| thr_q | output | 5 | Threshold register |
| lbd_flag | output | 1 | Sticky low-battery status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with PERIOD_TICKS = 16 and ACTIVE_TICKS = 2, and drives tick on every clock. With these values several full measurement windows, and their spacing, fit into a few dozen cycles. The default one-second period would need tens of thousands of ticks. RUN_LEN stays at 4 and the threshold reset at 0x14, so the vector table covers the real run length, the equal-to-threshold case and the re-arm after a status read.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int unsigned LBD_CODE_W = 5;
  typedef logic [LBD_CODE_W-1:0] lbd_code_t;
endpackage

// File: rtl/lbd_sched.sv
module lbd_sched #(
  parameter int unsigned PERIOD_TICKS = 32768,
  parameter int unsigned ACTIVE_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run_en,
  output logic meas_en
);
  localparam int unsigned CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);
  localparam logic [CW:0]   ACT  = (CW+1)'(ACTIVE_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cnt     <= '0;
      meas_en <= 1'b0;
    end else begin
      meas_en <= ({1'b0, cnt} < ACT);
      if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R9: measurement path is powered down while the function is off
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !meas_en);
endmodule

// File: rtl/lbd_filter.sv
module lbd_filter
  import lbd_pkg::*;
#(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      run_en,
  input  logic      done,
  input  lbd_code_t code,
  input  lbd_code_t thr,
  input  logic      clr,
  output lbd_code_t vbat,
  output logic      flag
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run;
  logic acc, low, hit;

  always_comb begin
    acc = run_en && done;
    low = code < thr;
    hit = acc && low && (run == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      vbat <= '0;
      flag <= 1'b0;
    end else begin
      if (!run_en)  run <= '0;
      else if (acc) begin
        vbat <= code;
        run  <= (!low || hit) ? '0 : run + 1'b1;
      end
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    run < RW'(RUN_LEN));
  assert_flag_needs_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(acc && low));
  assert_high_code_resets_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && !low) |=> (run == '0));
  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    (clr && !acc) |=> !flag);
  assert_vbat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(vbat));
  assert_run_cleared_off_R9: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (run == '0));
endmodule

// File: rtl/lbd_ctrl.sv
module lbd_ctrl
  import lbd_pkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 32768,
  parameter int unsigned ACTIVE_TICKS = 8,
  parameter int unsigned RUN_LEN      = 4,
  parameter logic [LBD_CODE_W-1:0] THR_RESET = 5'h14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  sleep,
  input  logic                  func_en,
  input  logic                  irq_en,
  input  logic                  thr_wr,
  input  logic [LBD_CODE_W-1:0] thr_wdata,
  input  logic                  meas_done,
  input  logic [LBD_CODE_W-1:0] meas_code,
  input  logic                  stat_rd,
  output logic                  meas_en,
  output logic                  slow_osc_en,
  output logic [LBD_CODE_W-1:0] vbat_q,
  output logic [LBD_CODE_W-1:0] thr_q,
  output logic                  lbd_flag,
  output logic                  irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q       <= THR_RESET;
      slow_osc_en <= 1'b0;
      irq_n       <= 1'b1;
    end else begin
      if (thr_wr) thr_q <= thr_wdata;
      slow_osc_en <= func_en && sleep;
      irq_n       <= !(lbd_flag && irq_en);
    end
  end

  lbd_sched #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .ACTIVE_TICKS(ACTIVE_TICKS)
  ) u_sched (
    .clk(clk), .rst(rst), .tick(tick), .run_en(func_en), .meas_en(meas_en)
  );

  lbd_filter #(
    .RUN_LEN(RUN_LEN)
  ) u_filt (
    .clk(clk), .rst(rst), .run_en(func_en), .done(meas_done),
    .code(meas_code), .thr(thr_q), .clr(stat_rd),
    .vbat(vbat_q), .flag(lbd_flag)
  );

  assert_irq_fires_R7: assert property (@(posedge clk) disable iff (rst)
    (lbd_flag && irq_en) |=> !irq_n);
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> irq_n);
  assert_thr_write_R2: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (thr_q == $past(thr_wdata)));
endmodule

// File: tb/sim_lbd_ctrl.sv
module sim_lbd_ctrl;
  logic clk = 1'b0;
  logic rst, tick, sleep, func_en, irq_en, thr_wr, meas_done, stat_rd;
  logic [4:0] thr_wdata, meas_code;
  logic meas_en, slow_osc_en, lbd_flag, irq_n;
  logic [4:0] vbat_q, thr_q;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lbd_ctrl #(.PERIOD_TICKS(16), .ACTIVE_TICKS(2)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .sleep(sleep), .func_en(func_en),
    .irq_en(irq_en), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .meas_done(meas_done), .meas_code(meas_code), .stat_rd(stat_rd),
    .meas_en(meas_en), .slow_osc_en(slow_osc_en), .vbat_q(vbat_q),
    .thr_q(thr_q), .lbd_flag(lbd_flag), .irq_n(irq_n));

  // {op (1=status read), code[4:0], expected flag}; threshold 0x14
  localparam logic [6:0] VEC [13] = '{
    {1'b0, 5'd19, 1'b0}, {1'b0, 5'd5, 1'b0}, {1'b0, 5'd0, 1'b0},
    {1'b0, 5'd19, 1'b1}, {1'b1, 5'd0, 1'b0}, {1'b0, 5'd3, 1'b0},
    {1'b0, 5'd3, 1'b0},  {1'b0, 5'd20, 1'b0}, {1'b0, 5'd3, 1'b0},
    {1'b0, 5'd3, 1'b0},  {1'b0, 5'd3, 1'b0},  {1'b0, 5'd3, 1'b1},
    {1'b1, 5'd0, 1'b0}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic meas(input logic [4:0] c);
    @(negedge clk); meas_done = 1'b1; meas_code = c;
    @(negedge clk); meas_done = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int hi;
    rst = 1; tick = 1; sleep = 0; func_en = 0; irq_en = 1; thr_wr = 0;
    thr_wdata = 0; meas_done = 0; meas_code = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 thr", thr_q, 'h14);   chk("R1 vbat", vbat_q, 0);
    chk("R1 flag", lbd_flag, 0);  chk("R1 irq_n", irq_n, 1);
    chk("R1 meas_en", meas_en, 0); chk("R1 osc", slow_osc_en, 0);

    // R9: disabled, strobes ignored and no measurement window
    hi = 0;
    for (int i = 0; i < 6; i++) meas(5'd1);
    chk("R9 vbat ignored", vbat_q, 0);
    chk("R9 flag ignored", lbd_flag, 0);
    for (int i = 0; i < 20; i++) begin @(negedge clk); hi += meas_en; end
    chk("R9 meas_en off", hi, 0);

    // R3: periodic window
    func_en = 1; hi = 0;
    for (int k = 1; k <= 48; k++) begin
      @(negedge clk);
      hi += meas_en;
      if (k == 1)  chk("R3 first window", meas_en, 1);
      if (k == 16) chk("R3 gap", meas_en, 0);
      if (k == 17) chk("R3 next window", meas_en, 1);
    end
    chk("R3 active count", hi, 6);

    // vector table: R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      if (VEC[i][6]) rd();
      else begin
        meas(VEC[i][5:1]);
        chk("R8 vbat", vbat_q, VEC[i][5:1]);
      end
      chk(VEC[i][6] ? "R6 flag after read" : "R4/R5 flag", lbd_flag, VEC[i][0]);
      @(negedge clk);
      chk("R7 irq_n", irq_n, !VEC[i][0]);
    end

    // R7 masked interrupt
    irq_en = 0;
    for (int i = 0; i < 4; i++) meas(5'd2);
    chk("R4 flag masked run", lbd_flag, 1);
    repeat (2) @(negedge clk);
    chk("R7 masked irq_n", irq_n, 1);
    rd(); irq_en = 1;

    // R9 disable mid-run resets the run
    for (int i = 0; i < 3; i++) meas(5'd2);
    @(negedge clk); func_en = 0; @(negedge clk); func_en = 1;
    meas(5'd2);
    chk("R9 run reset", lbd_flag, 0);
    for (int i = 0; i < 3; i++) meas(5'd2);
    chk("R9 run restarted", lbd_flag, 1);
    rd();

    // R2 threshold write, then compare against new value
    @(negedge clk); thr_wr = 1; thr_wdata = 5'd3;
    @(negedge clk); thr_wr = 0;
    chk("R2 thr", thr_q, 3);
    for (int i = 0; i < 4; i++) meas(5'd3);
    chk("R5 equal new thr", lbd_flag, 0);

    // R10 oscillator request
    sleep = 1; @(negedge clk);
    chk("R10 osc on", slow_osc_en, 1);
    func_en = 0; @(negedge clk);
    chk("R10 osc off", slow_osc_en, 0);

    summary();
  end
endmodule